// File: doc/BRIEF.md
# Timestamp and Pulse-Tick Generator

This block keeps a 56-bit free-running timestamp that advances by one on every cycle in which the crystal-rate tick enable is high. Two coarse timestamps, one for tagging and one for address-translation records, are derived from it. Each one is the base count shifted right by its own programmable amount. A programmable divider turns the crystal tick into a common timer tick. Three pulse generators count common ticks and each emits a single-cycle pulse at a selectable granularity of 100 us, 1 ms or 10 ms. With the usual divide-by-192 setting this gives a 100 kHz common tick.

Software programs the block through a write-only port with an address, a data word and a strobe. The intended sequence is to clear the divider enable, write the new divider value and the pulse granularities, and then set the enable again. The pulse generators pick up their granularity, and restart from zero, only at that re-enable.

Top module: `tsgen_top`

## Requirements
- R1: `base_ts` increases by exactly one, wrapping at 56 bits, in the cycle after each cycle in which `xo_tick` is high, and holds its value otherwise.
- R2: `tag_ts` equals `base_ts` shifted right by the tag shift (address 0, data bits 5:0), and `nat_ts` equals `base_ts` shifted right by the record shift (address 0, data bits 13:8), combinationally.
- R3: A shift setting of 56 or more makes the matching coarse timestamp zero.
- R4: The divider value lives at address 1, bits 15:0, and the enable at address 1, bit 31. While the enable is set, `timer_tick` is high for one cycle after every (value+1)-th `xo_tick`, so a value of 191 gives one tick per 192 crystal ticks.
- R5: While the divider enable is clear, `timer_tick` and all `pulse` bits stay low, and the divider count returns to zero.
- R6: The granularity fields sit at address 2: bits 1:0 for generator 0, bits 3:2 for generator 1 and bits 5:4 for generator 2. Code 0 gives one pulse per 10 common ticks, code 1 one per 100, and codes 2 and 3 one per 1000.
- R7: Each pulse lasts one cycle and appears in the cycle after the common tick that completes the period. On re-enable every generator counts from zero, so with divider value 0 and `xo_tick` always high, generator 0 at code 0 first pulses 11 cycles after the enabling write edge.
- R8: A granularity write made while the divider is enabled does not change the running period. It takes effect at the next re-enable.
- R9: Synchronous active-high reset clears the timestamp, the divider and pulse counts, all shifts, the divider value and its enable, and the granularities.
- R10: Writes to address 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xo_tick | input | 1 | Crystal-rate tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 32 | Register write data |
| base_ts | output | 56 | Free-running base timestamp |
| tag_ts | output | 56 | Coarse tag timestamp |
| nat_ts | output | 56 | Coarse address-translation timestamp |
| timer_tick | output | 1 | Common timer tick |
| pulse | output | 3 | Pulse generator outputs, bit i is generator i |

## Verification
The assertions assume that reset is held for at least one clock before any check applies. They also assume that inputs change only between clock edges. They do not assume that granularity writes happen only while the divider is disabled; that protocol rule is enforced by the design latching the granularity, and the bench breaks the rule on purpose to check R8. The stimulus drives every input on the falling edge. It runs both an always-high crystal tick and an irregular pseudo-random one. A bench model stepped on the rising edge predicts every output for the scoreboard.

// File: rtl/tsgen_pkg.sv
package tsgen_pkg;
  localparam int TS_W      = 56;
  localparam int SHIFT_W   = 6;
  localparam int DIV_W     = 16;
  localparam int NUM_PULSE = 3;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 2;
  localparam int GRAN_W    = 2;

  // field placement inside the write word
  localparam int TAG_SH_LSB = 0;
  localparam int NAT_SH_LSB = 8;
  localparam int DIV_VAL_LSB = 0;
  localparam int DIV_EN_BIT  = 31;

  // period lengths in common ticks
  localparam int PER_FINE   = 10;
  localparam int PER_MID    = 100;
  localparam int PER_COARSE = 1000;

  typedef enum logic [ADDR_W-1:0] {
    REG_SHIFT = 2'd0,
    REG_DIV   = 2'd1,
    REG_GRAN  = 2'd2,
    REG_NONE  = 2'd3
  } reg_addr_e;

  typedef enum logic [GRAN_W-1:0] {
    GRAN_100US = 2'd0,
    GRAN_1MS   = 2'd1,
    GRAN_10MS  = 2'd2,
    GRAN_RSVD  = 2'd3
  } gran_e;
endpackage

// File: rtl/tsgen_regs.sv
module tsgen_regs
  import tsgen_pkg::*;
#(
  parameter int SHIFT_P = SHIFT_W,
  parameter int DIVW_P  = DIV_W,
  parameter int NPUL_P  = NUM_PULSE,
  parameter int DW_P    = DATA_W,
  parameter int AW_P    = ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [AW_P-1:0]          wr_addr,
  input  logic [DW_P-1:0]          wr_data,
  output logic [SHIFT_P-1:0]       tag_sh,
  output logic [SHIFT_P-1:0]       nat_sh,
  output logic [DIVW_P-1:0]        div_val,
  output logic                     div_en,
  output logic [NPUL_P*GRAN_W-1:0] gran_word
);
  localparam int GWORD_W = NPUL_P * GRAN_W;

  logic shift_wr, div_wr, gran_wr;
  logic unused_wdata;

  assign shift_wr = wr_en && (wr_addr == AW_P'(REG_SHIFT));
  assign div_wr   = wr_en && (wr_addr == AW_P'(REG_DIV));
  assign gran_wr  = wr_en && (wr_addr == AW_P'(REG_GRAN));
  assign unused_wdata = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_sh <= '0;
      nat_sh <= '0;
    end else if (shift_wr) begin
      tag_sh <= wr_data[TAG_SH_LSB +: SHIFT_P];
      nat_sh <= wr_data[NAT_SH_LSB +: SHIFT_P];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_val <= '0;
      div_en  <= 1'b0;
    end else if (div_wr) begin
      div_val <= wr_data[DIV_VAL_LSB +: DIVW_P];
      div_en  <= wr_data[DIV_EN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) gran_word <= '0;
    else if (gran_wr) gran_word <= wr_data[GWORD_W-1:0];
  end
endmodule

// File: rtl/tsgen_stamp.sv
module tsgen_stamp
  import tsgen_pkg::*;
#(
  parameter int TSW_P   = TS_W,
  parameter int SHIFT_P = SHIFT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               xo_tick,
  input  logic [SHIFT_P-1:0] tag_sh,
  input  logic [SHIFT_P-1:0] nat_sh,
  output logic [TSW_P-1:0]   base_ts,
  output logic [TSW_P-1:0]   tag_ts,
  output logic [TSW_P-1:0]   nat_ts
);
  // coarse view: too-large shifts saturate to zero
  function automatic logic [TSW_P-1:0] coarse_view(input logic [TSW_P-1:0] ts,
                                                    input logic [SHIFT_P-1:0] sh);
    if (int'(sh) >= TSW_P) return '0;
    return ts >> sh;
  endfunction

  logic [TSW_P-1:0] ts_q;
  logic             ts_step;

  assign ts_step = xo_tick;

  always_ff @(posedge clk) begin
    if (rst)          ts_q <= '0;
    else if (ts_step) ts_q <= ts_q + TSW_P'(1);
  end

  assign base_ts = ts_q;
  assign tag_ts  = coarse_view(ts_q, tag_sh);
  assign nat_ts  = coarse_view(ts_q, nat_sh);
endmodule

// File: rtl/tsgen_divider.sv
module tsgen_divider
  import tsgen_pkg::*;
#(
  parameter int DIVW_P = DIV_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              xo_tick,
  input  logic [DIVW_P-1:0] div_val,
  output logic              tick,
  output logic              wrap
);
  logic [DIVW_P-1:0] cnt_q;

  assign wrap = run && xo_tick && (cnt_q == div_val);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= wrap;
      if (xo_tick) cnt_q <= wrap ? '0 : cnt_q + DIVW_P'(1);
    end
  end
endmodule

// File: rtl/tsgen_pulse.sv
module tsgen_pulse
  import tsgen_pkg::*;
#(
  parameter int FINE_P   = PER_FINE,
  parameter int MID_P    = PER_MID,
  parameter int COARSE_P = PER_COARSE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [GRAN_W-1:0] gran_sel,
  input  logic              tick,
  output logic              pulse,
  output logic              terminal
);
  localparam int CNT_W = $clog2(COARSE_P + 1);

  function automatic logic [CNT_W-1:0] period_len(input logic [GRAN_W-1:0] code);
    case (gran_e'(code))
      GRAN_100US: return CNT_W'(FINE_P);
      GRAN_1MS:   return CNT_W'(MID_P);
      default:    return CNT_W'(COARSE_P);
    endcase
  endfunction

  logic [GRAN_W-1:0] act_q;
  logic [CNT_W-1:0]  cnt_q;

  assign terminal = run && tick && (cnt_q == period_len(act_q) - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      cnt_q <= '0;
      pulse <= 1'b0;
    end else if (!run) begin
      act_q <= gran_sel;
      cnt_q <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= terminal;
      if (tick) cnt_q <= terminal ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/tsgen_top.sv
module tsgen_top
  import tsgen_pkg::*;
#(
  parameter int TSW_P   = TS_W,
  parameter int SHIFT_P = SHIFT_W,
  parameter int DIVW_P  = DIV_W,
  parameter int NPUL_P  = NUM_PULSE,
  parameter int DW_P    = DATA_W,
  parameter int AW_P    = ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xo_tick,
  input  logic              wr_en,
  input  logic [AW_P-1:0]   wr_addr,
  input  logic [DW_P-1:0]   wr_data,
  output logic [TSW_P-1:0]  base_ts,
  output logic [TSW_P-1:0]  tag_ts,
  output logic [TSW_P-1:0]  nat_ts,
  output logic              timer_tick,
  output logic [NPUL_P-1:0] pulse
);
  logic [SHIFT_P-1:0]       tag_sh, nat_sh;
  logic [DIVW_P-1:0]        div_val;
  logic                     div_en;
  logic [NPUL_P*GRAN_W-1:0] gran_word;
  logic                     div_wrap;
  logic [NPUL_P-1:0]        pulse_term;

  tsgen_regs #(
    .SHIFT_P(SHIFT_P), .DIVW_P(DIVW_P), .NPUL_P(NPUL_P), .DW_P(DW_P), .AW_P(AW_P)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tag_sh(tag_sh), .nat_sh(nat_sh), .div_val(div_val), .div_en(div_en),
    .gran_word(gran_word)
  );

  tsgen_stamp #(.TSW_P(TSW_P), .SHIFT_P(SHIFT_P)) u_stamp (
    .clk(clk), .rst(rst), .xo_tick(xo_tick), .tag_sh(tag_sh), .nat_sh(nat_sh),
    .base_ts(base_ts), .tag_ts(tag_ts), .nat_ts(nat_ts)
  );

  tsgen_divider #(.DIVW_P(DIVW_P)) u_div (
    .clk(clk), .rst(rst), .run(div_en), .xo_tick(xo_tick), .div_val(div_val),
    .tick(timer_tick), .wrap(div_wrap)
  );

  for (genvar g = 0; g < NPUL_P; g++) begin : g_pulse
    tsgen_pulse u_pg (
      .clk(clk), .rst(rst), .run(div_en),
      .gran_sel(gran_word[g*GRAN_W +: GRAN_W]),
      .tick(timer_tick), .pulse(pulse[g]), .terminal(pulse_term[g])
    );
  end
endmodule

// File: rtl/tsgen_chk.sv
module tsgen_chk #(
  parameter int TSW_P  = 56,
  parameter int NPUL_P = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              xo_tick,
  input logic              div_en,
  input logic              div_wrap,
  input logic              timer_tick,
  input logic [NPUL_P-1:0] pulse,
  input logic [NPUL_P-1:0] pulse_term,
  input logic [TSW_P-1:0]  base_ts,
  input logic [TSW_P-1:0]  tag_ts,
  input logic [TSW_P-1:0]  nat_ts
);
  AST_TS_STEP: assert property (@(posedge clk) disable iff (rst)
    xo_tick |=> base_ts == TSW_P'($past(base_ts) + TSW_P'(1))); // R1
  AST_TS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !xo_tick |=> $stable(base_ts)); // R1
  AST_COARSE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (tag_ts <= base_ts) && (nat_ts <= base_ts)); // R2
  AST_TICK_FROM_WRAP: assert property (@(posedge clk) disable iff (rst)
    div_wrap |=> timer_tick); // R4
  AST_TICK_NEEDS_XO: assert property (@(posedge clk) disable iff (rst)
    timer_tick |-> $past(xo_tick)); // R4
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !div_en |=> (!timer_tick && pulse == '0)); // R5
  AST_PULSE_AFTER_TERM: assert property (@(posedge clk) disable iff (rst)
    (pulse_term != '0) |=> (pulse == $past(pulse_term))); // R7
  AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    (pulse != '0) |-> $past(timer_tick)); // R7
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (pulse != '0) |=> (pulse == '0)); // R7
endmodule

bind tsgen_top tsgen_chk #(.TSW_P(TSW_P), .NPUL_P(NPUL_P)) u_chk (
  .clk(clk), .rst(rst), .xo_tick(xo_tick), .div_en(div_en), .div_wrap(div_wrap),
  .timer_tick(timer_tick), .pulse(pulse), .pulse_term(pulse_term),
  .base_ts(base_ts), .tag_ts(tag_ts), .nat_ts(nat_ts)
);

// File: tb/tsgen_top_test.sv
module tsgen_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xo_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [55:0] base_ts, tag_ts, nat_ts;
  logic        timer_tick;
  logic [2:0]  pulse;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  tsgen_top uut (
    .clk(clk), .rst(rst), .xo_tick(xo_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .base_ts(base_ts), .tag_ts(tag_ts), .nat_ts(nat_ts),
    .timer_tick(timer_tick), .pulse(pulse)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    n_checks++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // ---------------- reference model (stepped on rising edge) ----------------
  typedef struct packed {
    logic [55:0] ts, tag, nat;
    logic        tick;
    logic [2:0]  pul;
    logic        en;
    logic        big_tag, big_nat;
  } exp_t;
  exp_t q[$];

  logic [55:0] m_ts = '0;
  logic [5:0]  m_tsh = '0, m_nsh = '0;
  logic [15:0] m_dv = '0, m_dcnt = '0;
  logic        m_en = 0, m_tick = 0;
  logic [1:0]  m_gran[3] = '{default: '0};
  logic [1:0]  m_act[3]  = '{default: '0};
  int          m_pcnt[3] = '{default: 0};
  logic [2:0]  m_pul = '0;

  function automatic int ticks_per_pulse(input logic [1:0] code);
    if (code == 2'd0) return 10;
    if (code == 2'd1) return 100;
    return 1000;
  endfunction

  function automatic logic [55:0] scaled(input logic [55:0] t, input logic [5:0] s);
    if (s > 6'd55) return 56'd0;
    return t / (56'd1 << s);
  endfunction

  always @(posedge clk) begin
    exp_t e;
    if (rst) begin
      m_ts = '0; m_tsh = '0; m_nsh = '0; m_dv = '0; m_dcnt = '0;
      m_en = 0; m_tick = 0; m_pul = '0;
      for (int i = 0; i < 3; i++) begin m_gran[i] = '0; m_act[i] = '0; m_pcnt[i] = 0; end
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (!m_en) begin
          m_pcnt[i] = 0; m_act[i] = m_gran[i]; m_pul[i] = 1'b0;
        end else begin
          m_pul[i] = 1'b0;
          if (m_tick) begin
            m_pcnt[i]++;
            if (m_pcnt[i] == ticks_per_pulse(m_act[i])) begin
              m_pcnt[i] = 0; m_pul[i] = 1'b1;
            end
          end
        end
      end
      if (!m_en) begin
        m_dcnt = '0; m_tick = 0;
      end else if (xo_tick) begin
        m_tick = (m_dcnt == m_dv);
        m_dcnt = m_tick ? 16'd0 : m_dcnt + 16'd1;
      end else m_tick = 0;
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin m_tsh = wr_data[5:0]; m_nsh = wr_data[13:8]; end
          2'd1: begin m_dv = wr_data[15:0]; m_en = wr_data[31]; end
          2'd2: begin m_gran[0] = wr_data[1:0]; m_gran[1] = wr_data[3:2]; m_gran[2] = wr_data[5:4]; end
          default: ;
        endcase
      end
      if (xo_tick) m_ts = m_ts + 56'd1;
    end
    e.ts = m_ts; e.tag = scaled(m_ts, m_tsh); e.nat = scaled(m_ts, m_nsh);
    e.tick = m_tick; e.pul = m_pul; e.en = m_en;
    e.big_tag = (m_tsh >= 6'd56); e.big_nat = (m_nsh >= 6'd56);
    q.push_back(e);
  end

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (!done && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check("R1 base_ts", 64'(base_ts), 64'(e.ts));
      check(e.big_tag ? "R3 tag_ts" : "R2 tag_ts", 64'(tag_ts), 64'(e.tag));
      check(e.big_nat ? "R3 nat_ts" : "R2 nat_ts", 64'(nat_ts), 64'(e.nat));
      check(e.en ? "R4 timer_tick" : "R5 timer_tick", 64'(timer_tick), 64'(e.tick));
      check("R6 pulse", 64'(pulse), 64'(e.pul));
    end
  end

  // ---------------- driver ----------------
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // sel 0..2 = pulse bit, 3 = timer_tick
  function automatic logic probe(input int sel);
    return (sel == 3) ? timer_tick : pulse[sel];
  endfunction

  task automatic gap_of(input int sel, output int gap);
    do @(negedge clk); while (!probe(sel));
    gap = 0;
    do begin @(negedge clk); gap++; end while (!probe(sel));
  endtask

  initial begin
    int gap, cnt;
    logic [55:0] held;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 base_ts reset", 64'(base_ts), 64'd0);
    check("R9 tick/pulse reset", 64'({timer_tick, pulse}), 64'd0);
    rst = 1'b0;
    xo_tick = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 ticks stay off after reset", 64'(timer_tick), 64'd0);

    // R1 hold while crystal tick low
    xo_tick = 1'b0;
    @(negedge clk); held = base_ts;
    repeat (4) @(negedge clk);
    check("R1 hold without xo_tick", 64'(base_ts), 64'(held));
    xo_tick = 1'b1;

    // R2/R3 shifts: tag 4, record 60
    wr(2'd0, {18'd0, 6'd60, 2'd0, 6'd4});
    repeat (20) @(negedge clk);
    check("R3 nat_ts zero for large shift", 64'(nat_ts), 64'd0);
    check("R2 tag_ts shift 4", 64'(tag_ts), 64'(base_ts >> 4));

    // R10 unmapped address ignored
    wr(2'd3, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R10 shift unchanged", 64'(tag_ts), 64'(base_ts >> 4));
    check("R10 divider stays off", 64'(timer_tick), 64'd0);

    // R4 divide by 192
    wr(2'd1, 32'h8000_0000 | 32'd191);
    gap_of(3, gap);
    check("R4 tick period 192", 64'(gap), 64'd192);

    // R5 disabled: no ticks
    wr(2'd1, 32'd191);
    cnt = 0;
    repeat (300) begin @(negedge clk); if (timer_tick || pulse != 0) cnt++; end
    check("R5 no ticks when disabled", 64'(cnt), 64'd0);

    // R6/R7 granularities 0,1,2 with divider value 0
    wr(2'd2, {26'd0, 2'd2, 2'd1, 2'd0});
    wr(2'd1, 32'h8000_0000);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!pulse[0]);
    check("R7 first pulse after re-enable", 64'(cnt), 64'd11);
    gap_of(0, gap); check("R6 code 0 period", 64'(gap), 64'd10);
    gap_of(1, gap); check("R6 code 1 period", 64'(gap), 64'd100);
    gap_of(2, gap); check("R6 code 2 period", 64'(gap), 64'd1000);

    // R8 write while enabled does not take effect
    wr(2'd2, {26'd0, 2'd2, 2'd1, 2'd2});
    gap_of(0, gap); check("R8 period unchanged while enabled", 64'(gap), 64'd10);
    wr(2'd1, 32'd0);
    wr(2'd1, 32'h8000_0000);
    gap_of(0, gap); check("R8 new period after re-enable", 64'(gap), 64'd1000);

    // R6 reserved code 3
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd3);
    wr(2'd1, 32'h8000_0000);
    gap_of(0, gap); check("R6 code 3 period", 64'(gap), 64'd1000);

    // irregular crystal tick with divider value 3, scoreboard checks
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd0);
    wr(2'd0, {18'd0, 6'd7, 2'd0, 6'd56});
    wr(2'd1, 32'h8000_0003);
    repeat (800) begin @(negedge clk); xo_tick = ($urandom % 3) != 0; end
    xo_tick = 1'b1;
    repeat (4) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule